// File: doc/BRIEF.md
# Legacy Shadow Region Attribute Decoder

This block decides, for every access into the legacy area below 1 MB, whether that access is served by DRAM or passed on to the PCI bus. The upper 256 KB of the area is divided into thirteen segments. Each segment has a small attribute field that lives in a bank of byte-wide configuration registers. The field enables DRAM separately for reads and for writes. Firmware can therefore copy a ROM image into the DRAM underneath it and then write-protect that copy.

The 128 KB range starting at 0xA0000 is normally claimed by PCI for video. It can also be opened as system-management RAM. This is controlled by a control byte and by the processor's management-mode input. Decode results are combinational from the access inputs and the registered configuration state. A configuration write changes the registers on the clock edge that samples it.

The configuration port also returns a read-only byte. That byte holds the installed memory size in 8 MB units, taken from a static size input.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset, all seven attribute bytes read 0x00 and the window control byte reads 0x02. As a result, every segment access and every window access routes to PCI.
- R2: Attribute bytes sit at offsets 0x59 through 0x5F and the window control byte sits at 0x72. All of them are readable and writable. A write with cfg_we high is stored at the rising edge and is visible on cfg_rdata from then on.
- R3: Offset 0x57 reads the memory size in MB divided by 8, saturating at 255. Writes to 0x57 have no effect.
- R4: Any other offset reads 0x00. Writes to such offsets leave every register unchanged.
- R5: Any access at an address below 0xA0000 routes to DRAM, whatever the configuration.
- R6: Segment 0 covers 0xF0000 to 0xFFFFF. Segment k, for k from 1 to 12, covers the 16 KB block starting at 0xC0000 + (k-1)*0x4000.
- R7: Segment 0 uses the high nibble of byte 0x59. Segment k uses byte 0x59 + (k+1)/2: the low nibble when k is odd and the high nibble when k is even.
- R8: Within a nibble, bit 0 enables DRAM for reads and bit 1 enables DRAM for writes. When the bit for the access direction is clear, the access routes to PCI.
- R9: An access in 0xA0000 to 0xBFFFF routes to DRAM when control bit 6 is set, or when smm_active is high and control bit 3 is set. Otherwise it routes to PCI. Attribute bytes never affect this range.
- R10: When acc_valid is high, exactly one of to_dram and to_pci is high. When acc_valid is low, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr (combinational) |
| mem_size_mb | input | 16 | Installed memory in MB |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 20 | Access byte address |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| smm_active | input | 1 | Processor is in management mode |
| to_dram | output | 1 | Route current access to DRAM |
| to_pci | output | 1 | Route current access to PCI |

## Verification
The routing strobes and cfg_rdata respond in the same cycle as their inputs. The bench drives access and offset inputs on the falling edge and samples a couple of nanoseconds later, before the next rising edge. A configuration write holds cfg_we across exactly one rising edge. The bench updates its reference copy of the registers only after that edge, so every later check sees the new value. Random traffic mixes writes to the attribute bytes and the control byte with random reads and writes at all addresses and both states of management mode. Directed steps cover segment edges, nibble sharing, size saturation and offsets that must be ignored.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  typedef enum logic [1:0] {
    REG_LOW   = 2'd0,
    REG_WIN   = 2'd1,
    REG_SEG   = 2'd2
  } region_e;

  // Size in MB scaled down by 2**shift, clipped to one byte.
  function automatic logic [7:0] size_units(input logic [31:0] mb, input int unsigned shift);
    logic [31:0] u;
    u = mb >> shift;
    return (u > 32'd255) ? 8'hFF : u[7:0];
  endfunction

  // Which attribute byte (relative to the first) holds a segment's field.
  function automatic int unsigned byte_of_seg(input int unsigned seg);
    return (seg + 1) / 2;
  endfunction

  // Read/write enable pair of a segment out of its attribute byte.
  function automatic logic [1:0] en_of_seg(input logic [7:0] b, input int unsigned seg);
    return ((seg % 2) == 1) ? b[1:0] : b[5:4];
  endfunction

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
#(
  parameter int unsigned NUM_SEG    = 13,
  parameter int unsigned ATTR_BASE  = 'h59,
  parameter int unsigned SMRAM_OFF  = 'h72,
  parameter int unsigned RAMSZ_OFF  = 'h57,
  parameter logic [7:0]  SMRAM_RST  = 8'h02,
  parameter int unsigned RAM_SZ_W   = 16,
  parameter int unsigned UNIT_SHIFT = 3,
  localparam int unsigned ATTR_BYTES = NUM_SEG / 2 + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [7:0]             addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [RAM_SZ_W-1:0]    ram_mb,
  output logic [2*NUM_SEG-1:0]   seg_en,
  output logic [7:0]             smram_q,
  output logic                   remap_evt
);

  logic [7:0]  attr_q [ATTR_BYTES];
  logic [31:0] addr32;
  logic        hit_attr;
  logic        hit_smram;
  logic [7:0]  units;

  assign addr32    = 32'(addr);
  assign hit_attr  = (addr32 >= ATTR_BASE) && (addr32 < ATTR_BASE + ATTR_BYTES);
  assign hit_smram = (addr32 == SMRAM_OFF);
  assign remap_evt = we && (hit_attr || hit_smram);
  assign units     = size_units(32'(ram_mb), UNIT_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < ATTR_BYTES; b++) attr_q[b] <= 8'h00;
      smram_q <= SMRAM_RST;
    end else begin
      for (int b = 0; b < ATTR_BYTES; b++)
        if (we && addr32 == ATTR_BASE + b) attr_q[b] <= wdata;
      if (we && hit_smram) smram_q <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr32 == RAMSZ_OFF) rdata = units;
    if (hit_smram)           rdata = smram_q;
    for (int b = 0; b < ATTR_BYTES; b++)
      if (addr32 == ATTR_BASE + b) rdata = attr_q[b];
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg_en
    localparam int unsigned BI = byte_of_seg(s);
    assign seg_en[2*s +: 2] = en_of_seg(attr_q[BI], s);
  end

endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned NUM_SEG   = 13,
  parameter int unsigned SEG_SHIFT = 14,
  parameter int unsigned WIN_BASE  = 'hA0000,
  parameter int unsigned EXP_BASE  = 'hC0000,
  localparam int unsigned SEG_W     = $clog2(NUM_SEG),
  localparam int unsigned BIOS_BASE = EXP_BASE + ((NUM_SEG - 1) << SEG_SHIFT)
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr,
  input  logic [2*NUM_SEG-1:0]  seg_en,
  output region_e               region,
  output logic [SEG_W-1:0]      seg_idx,
  output logic                  seg_dram
);

  logic [31:0] a32;
  logic [31:0] rel;
  logic [1:0]  pick;

  assign a32 = 32'(addr);
  assign rel = a32 - EXP_BASE;

  always_comb begin
    if (a32 < WIN_BASE)      region = REG_LOW;
    else if (a32 < EXP_BASE) region = REG_WIN;
    else                     region = REG_SEG;
  end

  always_comb begin
    if (a32 >= BIOS_BASE) seg_idx = '0;
    else                  seg_idx = SEG_W'(32'd1 + (rel >> SEG_SHIFT));
  end

  always_comb begin
    pick = 2'b00;
    for (int s = 0; s < NUM_SEG; s++)
      if (seg_idx == SEG_W'(s)) pick = seg_en[2*s +: 2];
    seg_dram = wr ? pick[1] : pick[0];
  end

endmodule

// File: rtl/shadow_smram_gate.sv
module shadow_smram_gate (
  input  logic open_bit,
  input  logic en_bit,
  input  logic smm,
  output logic win_dram
);

  assign win_dram = open_bit || (smm && en_bit);

endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned NUM_SEG    = 13,
  parameter int unsigned SEG_SHIFT  = 14,
  parameter int unsigned WIN_BASE   = 'hA0000,
  parameter int unsigned WIN_SIZE   = 'h20000,
  parameter int unsigned ATTR_BASE  = 'h59,
  parameter int unsigned SMRAM_OFF  = 'h72,
  parameter int unsigned RAMSZ_OFF  = 'h57,
  parameter logic [7:0]  SMRAM_RST  = 8'h02,
  parameter int unsigned RAM_SZ_W   = 16,
  parameter int unsigned UNIT_SHIFT = 3,
  parameter int unsigned OPEN_BIT   = 6,
  parameter int unsigned EN_BIT     = 3,
  localparam int unsigned EXP_BASE  = WIN_BASE + WIN_SIZE,
  localparam int unsigned SEG_W     = $clog2(NUM_SEG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  input  logic [RAM_SZ_W-1:0]  mem_size_mb,
  input  logic                 acc_valid,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 acc_wr,
  input  logic                 smm_active,
  output logic                 to_dram,
  output logic                 to_pci
);

  logic [2*NUM_SEG-1:0] seg_en;
  logic [7:0]           smram_q;
  logic                 remap_evt;
  region_e              region;
  logic [SEG_W-1:0]     seg_idx;
  logic                 seg_dram;
  logic                 win_dram;
  logic                 dram_sel;

  shadow_cfg_regs #(
    .NUM_SEG(NUM_SEG), .ATTR_BASE(ATTR_BASE), .SMRAM_OFF(SMRAM_OFF),
    .RAMSZ_OFF(RAMSZ_OFF), .SMRAM_RST(SMRAM_RST), .RAM_SZ_W(RAM_SZ_W),
    .UNIT_SHIFT(UNIT_SHIFT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .ram_mb(mem_size_mb), .seg_en(seg_en),
    .smram_q(smram_q), .remap_evt(remap_evt)
  );

  shadow_seg_decode #(
    .ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .SEG_SHIFT(SEG_SHIFT),
    .WIN_BASE(WIN_BASE), .EXP_BASE(EXP_BASE)
  ) u_dec (
    .addr(acc_addr), .wr(acc_wr), .seg_en(seg_en),
    .region(region), .seg_idx(seg_idx), .seg_dram(seg_dram)
  );

  shadow_smram_gate u_win (
    .open_bit(smram_q[OPEN_BIT]), .en_bit(smram_q[EN_BIT]),
    .smm(smm_active), .win_dram(win_dram)
  );

  always_comb begin
    case (region)
      REG_LOW: dram_sel = 1'b1;
      REG_WIN: dram_sel = win_dram;
      default: dram_sel = seg_dram;
    endcase
  end

  assign to_dram = acc_valid && dram_sel;
  assign to_pci  = acc_valid && !dram_sel;

endmodule

// File: rtl/shadow_attr_decoder_chk.sv
module shadow_attr_decoder_chk
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned WIN_BASE  = 'hA0000,
  parameter int unsigned SMRAM_OFF = 'h72,
  parameter int unsigned OPEN_BIT  = 6,
  parameter int unsigned EN_BIT    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [7:0]        cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              smm_active,
  input logic              to_dram,
  input logic              to_pci,
  input logic [7:0]        smram_q,
  input logic              remap_evt,
  input region_e           region
);

  p_one_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({to_dram, to_pci}) == (acc_valid ? 1 : 0));

  p_low_dram_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && 32'(acc_addr) < WIN_BASE) |-> to_dram);

  p_win_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && region == REG_WIN && smram_q[OPEN_BIT]) |-> to_dram);

  p_win_shut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && region == REG_WIN && !smram_q[OPEN_BIT]
     && !(smm_active && smram_q[EN_BIT])) |-> to_pci);

  p_ctl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && 32'(cfg_addr) == SMRAM_OFF) |=> smram_q == $past(cfg_wdata));

  p_ctl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_evt |=> $stable(smram_q));

endmodule

bind shadow_attr_decoder shadow_attr_decoder_chk #(
  .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SMRAM_OFF(SMRAM_OFF),
  .OPEN_BIT(OPEN_BIT), .EN_BIT(EN_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .smm_active(smm_active), .to_dram(to_dram), .to_pci(to_pci),
  .smram_q(smram_q), .remap_evt(remap_evt), .region(region)
);

// File: tb/shadow_attr_decoder_bench.sv
module shadow_attr_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] mem_size_mb = 16'd0;
  logic        acc_valid = 1'b0;
  logic [19:0] acc_addr = 20'h0;
  logic        acc_wr = 1'b0;
  logic        smm_active = 1'b0;
  logic        to_dram;
  logic        to_pci;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] attr_m [7];
  logic [7:0] ctl_m;

  always #10 clk = ~clk;

  shadow_attr_decoder u_shadow_attr_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_size_mb(mem_size_mb),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .smm_active(smm_active), .to_dram(to_dram), .to_pci(to_pci)
  );

  // Reference routing, written from the requirement text.
  function automatic bit want_dram(input logic [19:0] a, input bit wr, input bit smm);
    int seg;
    logic [7:0] b;
    logic [3:0] nib;
    if (a < 20'hA0000) return 1'b1;
    if (a < 20'hC0000) return ctl_m[6] | (smm & ctl_m[3]);
    if (a >= 20'hF0000) seg = 0;
    else seg = (int'(a) - 'hC0000) / 'h4000 + 1;
    b = attr_m[(seg + 1) / 2];
    if (seg == 0)          nib = b[7:4];
    else if (seg % 2 == 1) nib = b[3:0];
    else                   nib = b[7:4];
    return wr ? nib[1] : nib[0];
  endfunction

  function automatic logic [7:0] want_read(input logic [7:0] off);
    int q;
    if (off >= 8'h59 && off <= 8'h5F) return attr_m[off - 8'h59];
    if (off == 8'h72) return ctl_m;
    if (off == 8'h57) begin
      q = int'(mem_size_mb) / 8;
      return (q > 255) ? 8'hFF : 8'(q);
    end
    return 8'h00;
  endfunction

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (off >= 8'h59 && off <= 8'h5F) attr_m[off - 8'h59] = d;
    if (off == 8'h72) ctl_m = d;
  endtask

  task automatic chk_read(input logic [7:0] off, input string req);
    logic [7:0] e;
    @(negedge clk);
    cfg_addr = off;
    #2;
    e = want_read(off);
    checks++;
    if (cfg_rdata !== e) begin
      errors++;
      $display("FAIL %s read off=%02h got %02h exp %02h", req, off, cfg_rdata, e);
    end
  endtask

  task automatic chk_route(input logic [19:0] a, input bit wr, input bit smm, input string req);
    bit e;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_wr = wr; smm_active = smm;
    #2;
    e = want_dram(a, wr, smm);
    checks++;
    if (to_dram !== e || to_pci !== !e) begin
      errors++;
      $display("FAIL %s addr=%05h wr=%0b smm=%0b got dram=%0b pci=%0b exp dram=%0b pci=%0b",
               req, a, wr, smm, to_dram, to_pci, e, !e);
    end
  endtask

  task automatic chk_idle(input logic [19:0] a);
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = a;
    #2;
    checks++;
    if (to_dram !== 1'b0 || to_pci !== 1'b0) begin
      errors++;
      $display("FAIL R10 idle got dram=%0b pci=%0b exp 0 0", to_dram, to_pci);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) attr_m[i] = 8'h00;
    ctl_m = 8'h02;
    mem_size_mb = 16'd512;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values and routes
    for (int i = 0; i < 7; i++) chk_read(8'(8'h59 + i), "R1");
    chk_read(8'h72, "R1");
    for (int s = 0; s < 12; s++) chk_route(20'(32'hC0000 + s * 32'h4000), s[0], 1'b0, "R1");
    chk_route(20'hF8000, 1'b0, 1'b0, "R1");
    chk_route(20'hA0000, 1'b0, 1'b1, "R1");

    // R3: size byte, saturation, write ignored
    mem_size_mb = 16'd7;     chk_read(8'h57, "R3");
    mem_size_mb = 16'd2040;  chk_read(8'h57, "R3");
    mem_size_mb = 16'd2047;  chk_read(8'h57, "R3");
    mem_size_mb = 16'd2048;  chk_read(8'h57, "R3");
    mem_size_mb = 16'hFFFF;  chk_read(8'h57, "R3");
    mem_size_mb = 16'd1000;
    cfg_write(8'h57, 8'h11); chk_read(8'h57, "R3");

    // R4: unmapped offsets read zero and writes are ignored
    cfg_write(8'h58, 8'hFF); cfg_write(8'h60, 8'hFF); cfg_write(8'h73, 8'hFF);
    chk_read(8'h58, "R4"); chk_read(8'h60, "R4"); chk_read(8'h00, "R4");
    chk_read(8'h59, "R4"); chk_read(8'h5F, "R4"); chk_read(8'h72, "R4");

    // R2: readback of every attribute byte and the control byte
    for (int i = 0; i < 7; i++) cfg_write(8'(8'h59 + i), 8'(8'hA5 ^ (i * 17)));
    for (int i = 0; i < 7; i++) chk_read(8'(8'h59 + i), "R2");
    cfg_write(8'h72, 8'h5C); chk_read(8'h72, "R2");

    // R7/R8: nibble sharing in byte 0x5A (seg1 low, seg2 high)
    cfg_write(8'h5A, 8'h21);
    chk_route(20'hC0000, 1'b0, 1'b0, "R7"); chk_route(20'hC0000, 1'b1, 1'b0, "R7");
    chk_route(20'hC4000, 1'b0, 1'b0, "R7"); chk_route(20'hC4000, 1'b1, 1'b0, "R7");
    cfg_write(8'h59, 8'h30);
    chk_route(20'hF0000, 1'b0, 1'b0, "R8"); chk_route(20'hFFFFF, 1'b1, 1'b0, "R8");
    cfg_write(8'h59, 8'h03);
    chk_route(20'hF4000, 1'b0, 1'b0, "R7"); chk_route(20'hF4000, 1'b1, 1'b0, "R7");

    // R6: segment edges with alternating patterns
    cfg_write(8'h5B, 8'h10); cfg_write(8'h5F, 8'h21);
    chk_route(20'hC7FFF, 1'b0, 1'b0, "R6"); chk_route(20'hC8000, 1'b0, 1'b0, "R6");
    chk_route(20'hCBFFF, 1'b0, 1'b0, "R6"); chk_route(20'hCC000, 1'b0, 1'b0, "R6");
    chk_route(20'hE8000, 1'b0, 1'b0, "R6"); chk_route(20'hEC000, 1'b1, 1'b0, "R6");
    chk_route(20'hEFFFF, 1'b1, 1'b0, "R6"); chk_route(20'hEBFFF, 1'b1, 1'b0, "R6");

    // R5: low area always DRAM
    for (int i = 0; i < 7; i++) cfg_write(8'(8'h59 + i), 8'h00);
    chk_route(20'h00000, 1'b0, 1'b0, "R5"); chk_route(20'h9FFFF, 1'b1, 1'b1, "R5");

    // R9: window gating, attributes irrelevant
    for (int i = 0; i < 7; i++) cfg_write(8'(8'h59 + i), 8'hFF);
    cfg_write(8'h72, 8'h08);
    chk_route(20'hA0000, 1'b0, 1'b0, "R9"); chk_route(20'hBFFFF, 1'b1, 1'b1, "R9");
    cfg_write(8'h72, 8'h40);
    chk_route(20'hB0000, 1'b0, 1'b0, "R9"); chk_route(20'hB0000, 1'b1, 1'b1, "R9");
    cfg_write(8'h72, 8'hB7);
    chk_route(20'hA8000, 1'b0, 1'b1, "R9"); chk_route(20'hC0000, 1'b0, 1'b1, "R9");

    // R10: idle strobes
    chk_idle(20'h12345); chk_idle(20'hF0000);

    // Random mix (R2, R5..R9 via reference model)
    void'($urandom(32'h5EED_0A11));
    for (int n = 0; n < 600; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k < 2) cfg_write(8'(8'h59 + $urandom_range(0, 6)), 8'($urandom));
      else if (k == 2) cfg_write(8'h72, 8'($urandom));
      else if (k == 3) chk_read(8'($urandom_range(8'h55, 8'h74)), "R2");
      else chk_route(20'($urandom), 1'($urandom), 1'($urandom), "R8");
    end

    chk_idle(20'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule